// File: doc/BRIEF.md
# Parallel Display Bus Command Master

This block drives the command port of a display controller over a parallel bus in the 8080 style. That bus has a chip select, a register select line that picks the control or the data register, separate write and read strobes, and a data bus of up to 18 bits. A host hands the master one operation at a time on a valid/ready port. Each operation is a word holding the bus data plus one extra register-select bit above it, a read/write flag, and a flag that marks the final operation of a command sequence.

For every operation the master sets register select, drives the data on writes or releases the bus on reads, and waits a set number of setup cycles. It then pulses the matching strobe for a set width and holds the bus for a set number of cycles afterwards. Chip select goes active with the first operation of a sequence and stays active through any mix of control writes, data writes and reads. It is released only after the operation flagged as last. On a read, the bus value is captured at the end of the strobe and returned on a one-cycle response pulse. The bus is modelled as separate output, output-enable and input vectors so that a pad ring can join them.

Top module: `pbus_cmd_master`

## Requirements
- R1: After reset and while idle, chip select, write strobe and read strobe sit at their inactive levels (high by default, because both polarities default to active-low), the bus output enable is low, the host port shows ready and no response is signalled.
- R2: Bit DW of the operation word (the bit just above the DW data bits) is the register select. 0 selects the control register and 1 selects the data register. The rsOut pin carries this bit unchanged for the whole operation.
- R3: An operation with the read flag low pulses only the write strobe. During that pulse the output enable is high and dbOut carries bits DW-1..0 of the word, unchanged for the whole pulse.
- R4: An operation with the read flag high pulses only the read strobe. dbIn is sampled on the last cycle of the pulse, and exactly one rspValid pulse of one cycle follows, carrying that value on rspData.
- R5: Every strobe pulse lasts exactly PULSE_CYC clock cycles.
- R6: Register select, output enable and, for writes, the data are stable with chip select active for at least SETUP_CYC cycles before a strobe asserts.
- R7: Register select, output enable and the bus data stay unchanged, with chip select active, for HOLD_CYC cycles after a strobe deasserts.
- R8: Chip select stays active across all operations of a sequence, including idle gaps between them, and goes inactive only after the hold of the operation flagged last.
- R9: The output enable is never high while the read strobe is active, and it never rises in the cycle right after a read strobe cycle. When the direction changes within a sequence, at least one cycle with the bus released separates the operations.
- R10: The host port is ready only while idle or between operations of an open sequence, never during setup, strobe or hold. Every accepted operation produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Host offers an operation |
| opReady | output | 1 | Master accepts the offered operation this cycle |
| opWord | input | DW+1 | Bit DW register select, bits DW-1..0 bus data |
| opRead | input | 1 | 1 for a read operation, 0 for a write |
| opLast | input | 1 | Operation closes the sequence and frees chip select |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspData | output | DW | Value captured from the bus on a read |
| csOut | output | 1 | Chip select |
| rsOut | output | 1 | Register select, 0 control, 1 data |
| wrOut | output | 1 | Write strobe |
| rdOut | output | 1 | Read strobe |
| dbOut | output | DW | Bus value driven on writes |
| dbOe | output | 1 | Bus output enable |
| dbIn | input | DW | Bus value seen at the pads |

## Verification
The assertions take for granted that the host keeps opWord, opRead and opLast steady while opValid waits for ready. They also assume that the display side returns a settled value on dbIn by the end of each read strobe. The stimulus applies each word at a falling edge and holds it until the master accepts it. A bench model of the display drives dbIn from a per-read counter only while the read strobe is active and drives a different value otherwise, so a capture on the wrong cycle shows up. Sequences of random length mix control and data registers and both directions, with random idle gaps, and a few directed sequences force turnarounds and single-operation sequences.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_SETUP,
    S_STROBE,
    S_HOLD,
    S_GAP
  } pbmState_t;

  // strobes from the sequencer to the bus datapath
  typedef struct packed {
    logic load;     // latch the accepted operation word
    logic capture;  // sample the bus into the response register
    logic driveEn;  // enable the bus drivers
    logic csOn;     // chip select asserted
    logic wrOn;     // write strobe asserted
    logic rdOn;     // read strobe asserted
  } pbmCtl_t;

endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    opRead,
  input  logic    opLast,
  output logic    opReady,
  output pbmCtl_t ctl
);

  localparam int MAXA = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC = (MAXA > HOLD_CYC) ? MAXA : HOLD_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  pbmState_t     state;
  logic [CW-1:0] cnt;
  logic          curRead;
  logic          curLast;
  logic          accept;

  assign opReady = (state == S_IDLE) || (state == S_GAP);
  assign accept  = opValid && opReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      curRead <= 1'b0;
      curLast <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_GAP: begin
          if (accept) begin
            curRead <= opRead;
            curLast <= opLast;
            cnt     <= '0;
            // a direction change inside a sequence costs one released cycle
            state   <= (state == S_GAP && opRead != curRead) ? S_TURN : S_SETUP;
          end
        end
        S_TURN: state <= S_SETUP;
        S_SETUP: begin
          if (cnt == CW'(SETUP_CYC - 1)) begin
            cnt   <= '0;
            state <= S_STROBE;
          end else cnt <= cnt + CW'(1);
        end
        S_STROBE: begin
          if (cnt == CW'(PULSE_CYC - 1)) begin
            cnt   <= '0;
            state <= S_HOLD;
          end else cnt <= cnt + CW'(1);
        end
        S_HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) begin
            cnt   <= '0;
            state <= curLast ? S_IDLE : S_GAP;
          end else cnt <= cnt + CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = accept;
    ctl.csOn    = (state != S_IDLE);
    ctl.wrOn    = (state == S_STROBE) && !curRead;
    ctl.rdOn    = (state == S_STROBE) && curRead;
    ctl.driveEn = !curRead &&
                  ((state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD));
    ctl.capture = (state == S_STROBE) && curRead && (cnt == CW'(PULSE_CYC - 1));
  end

endmodule

// File: rtl/pbm_dp.sv
module pbm_dp
  import pbm_pkg::*;
#(
  parameter int DW        = 18,
  parameter bit CS_LOW    = 1'b1,
  parameter bit STB_LOW   = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW:0]   opWord,
  input  pbmCtl_t       ctl,
  input  logic [DW-1:0] dbIn,
  output logic          csOut,
  output logic          rsOut,
  output logic          wrOut,
  output logic          rdOut,
  output logic [DW-1:0] dbOut,
  output logic          dbOe,
  output logic [DW-1:0] rspData,
  output logic          rspValid
);

  logic          rsReg;
  logic [DW-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsReg    <= 1'b0;
      dataReg  <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (ctl.load) begin
        rsReg   <= opWord[DW];
        dataReg <= opWord[DW-1:0];
      end
      if (ctl.capture) rspData <= dbIn;
      rspValid <= ctl.capture;
    end
  end

  assign csOut = CS_LOW  ? ~ctl.csOn : ctl.csOn;
  assign wrOut = STB_LOW ? ~ctl.wrOn : ctl.wrOn;
  assign rdOut = STB_LOW ? ~ctl.rdOn : ctl.rdOn;
  assign rsOut = rsReg;
  assign dbOe  = ctl.driveEn;
  assign dbOut = ctl.driveEn ? dataReg : '0;

endmodule

// File: rtl/pbus_cmd_master.sv
module pbus_cmd_master
  import pbm_pkg::*;
#(
  parameter int DW          = 18,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 1,
  parameter bit CS_ACT_LOW  = 1'b1,
  parameter bit STB_ACT_LOW = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  output logic          opReady,
  input  logic [DW:0]   opWord,
  input  logic          opRead,
  input  logic          opLast,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic          csOut,
  output logic          rsOut,
  output logic          wrOut,
  output logic          rdOut,
  output logic [DW-1:0] dbOut,
  output logic          dbOe,
  input  logic [DW-1:0] dbIn
);

  pbmCtl_t ctl;

  pbm_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opRead (opRead),
    .opLast (opLast),
    .opReady(opReady),
    .ctl    (ctl)
  );

  pbm_dp #(
    .DW     (DW),
    .CS_LOW (CS_ACT_LOW),
    .STB_LOW(STB_ACT_LOW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opWord  (opWord),
    .ctl     (ctl),
    .dbIn    (dbIn),
    .csOut   (csOut),
    .rsOut   (rsOut),
    .wrOut   (wrOut),
    .rdOut   (rdOut),
    .dbOut   (dbOut),
    .dbOe    (dbOe),
    .rspData (rspData),
    .rspValid(rspValid)
  );

endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
  parameter int DW          = 18,
  parameter int PULSE_CYC   = 3,
  parameter bit CS_ACT_LOW  = 1'b1,
  parameter bit STB_ACT_LOW = 1'b1
) (
  input logic          clk,
  input logic          rstN,
  input logic          opReady,
  input logic          rspValid,
  input logic          csOut,
  input logic          rsOut,
  input logic          wrOut,
  input logic          rdOut,
  input logic [DW-1:0] dbOut,
  input logic          dbOe
);

  logic wrAct, rdAct, csAct, stbAct;
  logic [15:0] stbCnt;

  assign wrAct  = (wrOut == ~STB_ACT_LOW);
  assign rdAct  = (rdOut == ~STB_ACT_LOW);
  assign csAct  = (csOut == ~CS_ACT_LOW);
  assign stbAct = wrAct || rdAct;

  // counts strobe cycles already seen in the current pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbCnt <= '0;
    else if (stbAct) stbCnt <= stbCnt + 16'd1;
    else stbCnt <= '0;
  end

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAct && rdAct));

  a_r3_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && $past(wrAct)) |-> ($stable(dbOut) && $stable(rsOut) && dbOe));

  a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r5_pulse_short: assert property (@(posedge clk) disable iff (!rstN)
    stbAct |-> (stbCnt < 16'(PULSE_CYC)));

  a_r5_pulse_full: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stbAct) |-> ($past(stbCnt) == 16'(PULSE_CYC - 1)));

  a_r8_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    stbAct |-> csAct);

  a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rdAct |-> !dbOe);

  a_r9_turn_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbOe) |-> !$past(rdAct));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    stbAct |-> !opReady);

endmodule

bind pbus_cmd_master pbm_checker #(
  .DW         (DW),
  .PULSE_CYC  (PULSE_CYC),
  .CS_ACT_LOW (CS_ACT_LOW),
  .STB_ACT_LOW(STB_ACT_LOW)
) u_pbm_checker (
  .clk     (clk),
  .rstN    (rstN),
  .opReady (opReady),
  .rspValid(rspValid),
  .csOut   (csOut),
  .rsOut   (rsOut),
  .wrOut   (wrOut),
  .rdOut   (rdOut),
  .dbOut   (dbOut),
  .dbOe    (dbOe)
);

// File: tb/pbus_cmd_master_bench.sv
`timescale 1ns/1ps
module pbus_cmd_master_bench;

  localparam int DW    = 18;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 1;
  localparam int MAXOP = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic          opReady;
  logic [DW:0]   opWord = '0;
  logic          opRead = 1'b0;
  logic          opLast = 1'b0;
  logic          rspValid;
  logic [DW-1:0] rspData;
  logic          csOut, rsOut, wrOut, rdOut, dbOe;
  logic [DW-1:0] dbOut;
  logic [DW-1:0] dbIn;

  always #2.5 clk = ~clk;

  pbus_cmd_master #(
    .DW(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD)
  ) u_pbus_cmd_master (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opWord(opWord), .opRead(opRead), .opLast(opLast),
    .rspValid(rspValid), .rspData(rspData), .csOut(csOut), .rsOut(rsOut),
    .wrOut(wrOut), .rdOut(rdOut), .dbOut(dbOut), .dbOe(dbOe), .dbIn(dbIn)
  );

  int nChk = 0;
  int nBad = 0;

  function automatic logic [DW-1:0] slaveVal(int i);
    return DW'(i * 32'h2F1B + 32'h155);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected operations, filled by the driver
  logic          expRs [MAXOP];
  logic [DW-1:0] expDat[MAXOP];
  logic          expRd [MAXOP];
  int            expN = 0;
  int            nReads = 0;
  int            seqLen[256];
  int            seqN = 0;
  int            curSeqCnt = 0;

  // display model: drives the bus only while the read strobe is active
  int rdSlave = 0;
  assign dbIn = (!rdOut) ? slaveVal(rdSlave) : ~slaveVal(rdSlave);

  // bus monitor
  int            mIdx = 0, rspIdx = 0, stableRun = 0, pulseLen = 0, holdLeft = 0;
  int            strobesInCs = 0, csSeq = 0;
  logic [DW+1:0] sig, prevSig, startSig;
  bit            wA, rA, cA, prevW, prevR, prevC, startIsRd;

  always @(negedge clk) begin
    if (!rstN) begin
      prevW = 0; prevR = 0; prevC = 0; stableRun = 0; holdLeft = 0;
      prevSig = '0;
    end else begin
      wA = !wrOut; rA = !rdOut; cA = !csOut;
      sig = {rsOut, dbOe, dbOut};
      if ((wA || rA) && opReady) check(0, "R10", "ready during strobe", 1, 0);
      if (wA && rA) check(0, "R3", "both strobes active", 1, 0);
      if (wA || rA) begin
        if (!(prevW || prevR)) begin
          check(stableRun >= SETUP, "R6", "setup cycles", stableRun, SETUP);
          check(cA, "R8", "chip select at strobe", cA, 1);
          if (wA) check(dbOe, "R3", "bus driven on write", dbOe, 1);
          else    check(!dbOe, "R9", "bus released on read", dbOe, 0);
          startSig = sig; startIsRd = rA; pulseLen = 1;
        end else begin
          pulseLen++;
          if (sig != startSig) check(0, "R6", "lines moved in strobe", sig, startSig);
        end
        stableRun = 0; holdLeft = 0;
      end else begin
        if (prevW || prevR) begin
          check(pulseLen == PULSE, "R5", "strobe width", pulseLen, PULSE);
          if (mIdx < expN) begin
            check(startIsRd == expRd[mIdx], "R3", "direction", startIsRd, expRd[mIdx]);
            check(startSig[DW+1] == expRs[mIdx], "R2", "register select",
                  startSig[DW+1], expRs[mIdx]);
            if (!startIsRd)
              check(startSig[DW-1:0] == expDat[mIdx], "R3", "write data",
                    startSig[DW-1:0], expDat[mIdx]);
          end else check(0, "R10", "extra strobe", mIdx, expN);
          mIdx++; strobesInCs++;
          if (startIsRd) rdSlave++;
          holdLeft = HOLD;
        end
        if (holdLeft > 0) begin
          check(sig == startSig && cA, "R7", "hold lines", sig, startSig);
          holdLeft--;
        end
        if (cA && prevC && sig == prevSig) stableRun++;
        else stableRun = cA ? 1 : 0;
      end
      if (rspValid) begin
        check(rspData == slaveVal(rspIdx), "R4", "read data", rspData, slaveVal(rspIdx));
        rspIdx++;
      end
      if (prevC && !cA) begin
        check(strobesInCs == seqLen[csSeq], "R8", "operations under one select",
              strobesInCs, seqLen[csSeq]);
        csSeq++; strobesInCs = 0;
      end
      prevW = wA; prevR = rA; prevC = cA; prevSig = sig;
    end
  end

  task automatic issueOp(bit rs, logic [DW-1:0] d, bit rd, bit last);
    expRs[expN] = rs; expDat[expN] = d; expRd[expN] = rd; expN++;
    if (rd) nReads++;
    curSeqCnt++;
    if (last) begin
      seqLen[seqN] = curSeqCnt; seqN++; curSeqCnt = 0;
    end
    @(negedge clk);
    opValid = 1'b1; opWord = {rs, d}; opRead = rd; opLast = last;
    while (!opReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; opWord = '1; opRead = ~rd; opLast = ~last;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset levels, active-low defaults
    check(csOut && wrOut && rdOut, "R1", "idle strobe levels", {csOut, wrOut, rdOut}, 3'b111);
    check(!dbOe && opReady && !rspValid, "R1", "idle oe/ready/rsp",
          {dbOe, opReady, rspValid}, 3'b010);

    // directed: control write, two data writes, data read, control read
    issueOp(1'b0, 18'h0002C, 1'b0, 1'b0);
    issueOp(1'b1, 18'h3FFFF, 1'b0, 1'b0);
    issueOp(1'b1, 18'h00001, 1'b0, 1'b0);
    issueOp(1'b1, 18'h00000, 1'b1, 1'b0);
    issueOp(1'b0, 18'h00000, 1'b1, 1'b1);
    idle(4);
    // single write sequence
    issueOp(1'b0, 18'h2AAAA, 1'b0, 1'b1);
    // read, write, read with turnarounds (R9) and gaps inside the sequence (R8)
    issueOp(1'b1, 18'h00000, 1'b1, 1'b0);
    idle(3);
    issueOp(1'b1, 18'h15555, 1'b0, 1'b0);
    issueOp(1'b1, 18'h00000, 1'b1, 1'b1);
    // single read, back to back with next sequence
    issueOp(1'b1, 18'h00000, 1'b1, 1'b1);
    issueOp(1'b0, 18'h00000, 1'b1, 1'b0);
    issueOp(1'b0, 18'h00000, 1'b1, 1'b1);
    check(!opReady, "R10", "busy after accepting", opReady, 0);

    // random sequences
    for (int s = 0; s < 40; s++) begin
      int len;
      len = 1 + int'($urandom % 5);
      for (int k = 0; k < len; k++) begin
        issueOp(1'($urandom), DW'($urandom), ($urandom % 3) == 0, k == len - 1);
        idle(int'($urandom % 3));
      end
      idle(int'($urandom % 4));
    end

    idle(20);
    check(mIdx == expN, "R10", "one strobe per operation", mIdx, expN);
    check(rspIdx == nReads, "R4", "one response per read", rspIdx, nReads);
    check(csSeq == seqN, "R8", "select released per sequence", csSeq, seqN);
    check(csOut && opReady && !dbOe, "R1", "idle after traffic",
          {csOut, opReady, dbOe}, 3'b110);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule